// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host-side master for a three-wire sampling converter with a 12-bit result. The converter's data line changes on the falling edges of the serial clock. The block derives the active-low select line and the serial clock from the system clock. The clock divider is a parameter. Each frame has an acquisition stretch with select high, then a conversion stretch with select low. During the conversion stretch the block gathers the bits that the converter shifts out.

A frame has two possible triggers. A one-cycle request starts a single frame, and the serial clock then rests high through acquisition. A continuous-run input chains frames back to back, and the serial clock never pauses. Each frame carries two leading zero bits, then twelve data bits MSB first, then trailing zeros. The block checks both leading zeros and the first trailing zero, and it flags a framing error when any of them reads as one. The converter returns the sample taken one frame earlier. For that reason the first result after reset carries a stale marker.

Top module: `adc_read_ctrl`

## Requirements
- R1: While reset is applied and afterwards until a frame is requested, select and serial clock are both high, busy is low, and the valid strobe and the framing error are low.
- R2: Every low level of the serial clock, and every high level after the first falling edge of a conversion stretch, lasts exactly HALF_DIV system clock cycles (default 2).
- R3: In request mode the serial clock holds high through an acquisition stretch of 4 serial-clock periods with select high. Select falls while the clock is high. Exactly 14 falling edges occur with select low, and select rises together with the rising edge that follows the 14th falling edge.
- R4: In continuous mode every frame lasts 18 serial-clock periods (36*HALF_DIV system cycles, select fall to select fall). Select is high for 8 half periods, and 4 falling edges occur within that high stretch.
- R5: A bit is captured at the end of each low half period of a conversion stretch. One more bit is captured at the end of the first half period with select low, before any falling edge. Result bit 11 is the bit shifted out after the 2nd falling edge, and result bit 0 is the bit after the 13th.
- R6: The valid strobe is high for exactly one system cycle, on the edge that ends the half period after the 14th falling edge. The result stays unchanged until the next strobe.
- R7: The first valid strobe after reset has the stale marker set, and every later strobe has it clear. The marker is only ever high together with the strobe.
- R8: The framing error is updated with each strobe. It is 1 when the bit captured before the first falling edge, the bit after the first falling edge, or the bit after the 14th falling edge is 1, and 0 otherwise. The result is delivered either way.
- R9: A request while a frame is in progress is ignored. When continuous mode is dropped during a frame, that frame completes and the lines return to idle with no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Start one frame when idle |
| free_run_i | input | 1 | Chain frames with a free-running serial clock |
| adc_sdo_i | input | 1 | Serial data from the converter |
| adc_cs_n_o | output | 1 | Active-low select to the converter |
| adc_sck_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | A frame is in progress |
| result_o | output | DATA_W | Last delivered conversion result |
| result_valid_o | output | 1 | One-cycle strobe for a new result |
| result_stale_o | output | 1 | Marks the first result after reset |
| frame_err_o | output | 1 | Leading or trailing zero read as one |

## Verification
In continuous mode one system clock edge does three things at once: it captures the last framing bit, it raises the result strobe, and it launches the next frame by raising select and the serial clock. The bench stresses that edge by dropping continuous mode in the cycle right after a strobe. It then expects exactly one more frame and a return to idle, and it measures frame period, select-high width and clock-level widths at the pins. A second overlap is a request that arrives in the middle of a frame. That request must leave no trace, and the bench confirms this by counting select falls over the following idle stretch.

// File: rtl/adc_rd_pkg.sv
// Shared definitions for the serial ADC read controller.
package adc_rd_pkg;

    // Serial clock behaviour during the acquisition stretch of a frame.
    typedef enum logic {
        SCK_HELD = 1'b0,   // clock rests high while select is high
        SCK_FREE = 1'b1    // clock keeps toggling, frames chained
    } sck_mode_e;

    // Number of serial half periods in one frame.
    function automatic int frame_halves(input int acq_per, input int conv_per);
        return 2 * (acq_per + conv_per);
    endfunction

endpackage

// File: rtl/adc_rd_sck_gen.sv
// Frame sequencer: divides the system clock into serial half periods,
// walks a phase counter through one frame and drives select and serial
// clock from registers. Phases below 2*ACQ_PER are acquisition (select
// high), the rest conversion. Even phases drive the clock high, odd ones
// low. Assumes ACQ_PER >= 1 and CONV_PER >= 2.
module adc_rd_sck_gen
    import adc_rd_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int ACQ_PER  = 4,
    parameter int CONV_PER = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic free_i,
    output logic busy_o,
    output logic cs_n_o,
    output logic sck_o,
    output logic smp_o,
    output logic last_o
);
    localparam int FRAME_H = frame_halves(ACQ_PER, CONV_PER);
    localparam int ACQ_H   = 2 * ACQ_PER;
    localparam int PH_W    = $clog2(FRAME_H);
    localparam int DIV_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(FRAME_H - 1);
    localparam logic [PH_W-1:0]  PH_CS    = PH_W'(ACQ_H);

    logic [DIV_W-1:0] div_q;
    logic [PH_W-1:0]  ph_q, ph_d;
    logic             busy_q, busy_d;
    sck_mode_e        mode_q, mode_d;
    logic             cs_n_q, cs_n_d;
    logic             sck_q, sck_d;
    logic             tick, at_end;

    assign tick   = busy_q && (div_q == DIV_LAST);
    assign at_end = (ph_q == PH_LAST);

    // Next frame state: launch from idle, advance on each half-period tick.
    always_comb begin
        busy_d = busy_q;
        ph_d   = ph_q;
        mode_d = mode_q;
        if (!busy_q) begin
            if (start_i || free_i) begin
                busy_d = 1'b1;
                ph_d   = '0;
                mode_d = free_i ? SCK_FREE : SCK_HELD;
            end
        end else if (tick) begin
            if (at_end) begin
                if (free_i) begin
                    ph_d   = '0;
                    mode_d = SCK_FREE;
                end else begin
                    busy_d = 1'b0;
                end
            end else begin
                ph_d = ph_q + 1'b1;
            end
        end
    end

    // Pin levels for the next phase, so the pads come straight from flops.
    always_comb begin
        cs_n_d = !(busy_d && (ph_d >= PH_CS));
        sck_d  = !busy_d || !ph_d[0] || ((ph_d < PH_CS) && (mode_d == SCK_HELD));
    end

    // State and pad registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ph_q   <= '0;
            div_q  <= '0;
            mode_q <= SCK_HELD;
            cs_n_q <= 1'b1;
            sck_q  <= 1'b1;
        end else begin
            busy_q <= busy_d;
            ph_q   <= ph_d;
            mode_q <= mode_d;
            cs_n_q <= cs_n_d;
            sck_q  <= sck_d;
            div_q  <= (!busy_q || tick) ? '0 : div_q + 1'b1;
        end
    end

    // Capture at the end of the first select-low half and of every low half.
    assign smp_o  = tick && (ph_q >= PH_CS) && ((ph_q == PH_CS) || ph_q[0]);
    assign last_o = tick && at_end;
    assign busy_o = busy_q;
    assign cs_n_o = cs_n_q;
    assign sck_o  = sck_q;

    AST_CS_FALL_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_q) |-> sck_q); // R3
    AST_ACQ_SCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SCK_HELD && cs_n_q) |-> sck_q); // R3
    AST_CS_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_q) |-> $past(!sck_q)); // R3
    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !$past(busy_q)) |-> (cs_n_q && sck_q)); // R1

endmodule

// File: rtl/adc_rd_capture.sv
// Bit capture and framing check: shifts in one bit per sample strobe and,
// on the final strobe of a frame, publishes the data word, the framing
// verdict and the stale marker. Assumes the sequencer gives exactly
// LEAD + DATA_W + 1 strobes per frame, the last one flagged.
module adc_rd_capture #(
    parameter int DATA_W = 12,
    parameter int LEAD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdo_i,
    input  logic              smp_i,
    input  logic              last_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              stale_o,
    output logic              err_o
);
    localparam int SMP   = LEAD + DATA_W + 1;
    localparam int CNT_W = $clog2(SMP + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SMP - 1);

    logic [SMP-2:0]   sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             seen_q;

    // Shift register and per-frame bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (smp_i) begin
            sh_q  <= {sh_q[SMP-3:0], sdo_i};
            cnt_q <= last_i ? '0 : cnt_q + 1'b1;
        end
    end

    // Result publication on the final strobe of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
            stale_o <= 1'b0;
            err_o   <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            valid_o <= last_i;
            stale_o <= last_i && !seen_q;
            if (last_i) begin
                data_o <= sh_q[DATA_W-1:0];
                err_o  <= (|sh_q[SMP-2:DATA_W]) | sdo_i;
                seen_q <= 1'b1;
            end
        end
    end

    AST_LAST_ON_FINAL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        last_i |-> (smp_i && cnt_q == CNT_LAST)); // R5
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R6
    AST_STALE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        stale_o |-> valid_o); // R7
    AST_ERR_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_o) |-> valid_o); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o)); // R6

endmodule

// File: rtl/adc_read_ctrl.sv
// Top of the serial ADC read controller: joins the frame sequencer to the
// bit capture. The converter's data line is taken directly. It is assumed
// to be stable for a full half period before each capture edge.
module adc_read_ctrl #(
    parameter int HALF_DIV    = 2,
    parameter int DATA_W      = 12,
    parameter int LEAD_ZEROS  = 2,
    parameter int ACQ_PERIODS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              free_run_i,
    input  logic              adc_sdo_i,
    output logic              adc_cs_n_o,
    output logic              adc_sck_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] result_o,
    output logic              result_valid_o,
    output logic              result_stale_o,
    output logic              frame_err_o
);
    localparam int CONV_PERIODS = LEAD_ZEROS + DATA_W;

    logic smp, last;

    adc_rd_sck_gen #(
        .HALF_DIV (HALF_DIV),
        .ACQ_PER  (ACQ_PERIODS),
        .CONV_PER (CONV_PERIODS)
    ) u_sck_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (req_i),
        .free_i  (free_run_i),
        .busy_o  (busy_o),
        .cs_n_o  (adc_cs_n_o),
        .sck_o   (adc_sck_o),
        .smp_o   (smp),
        .last_o  (last)
    );

    adc_rd_capture #(
        .DATA_W (DATA_W),
        .LEAD   (LEAD_ZEROS)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .sdo_i   (adc_sdo_i),
        .smp_i   (smp),
        .last_i  (last),
        .data_o  (result_o),
        .valid_o (result_valid_o),
        .stale_o (result_stale_o),
        .err_o   (frame_err_o)
    );

endmodule

// File: tb/adc_read_ctrl_bench.sv
// Directed bench: a behavioural converter model, a pin monitor and one
// task per scenario.
module adc_read_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic free_run = 1'b0;
    logic sdo = 1'b0;
    logic cs_n, sck, busy, valid, stale, ferr;
    logic [11:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_read_ctrl #(.HALF_DIV(HALF)) u_adc_read_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req), .free_run_i(free_run),
        .adc_sdo_i(sdo), .adc_cs_n_o(cs_n), .adc_sck_o(sck), .busy_o(busy),
        .result_o(result), .result_valid_o(valid), .result_stale_o(stale),
        .frame_err_o(ferr)
    );

    // ---------------- converter model ----------------
    typedef struct packed { logic [11:0] w; logic e; } exp_t;
    exp_t exp_q[$];
    logic [11:0] prev_w = '0;
    logic [11:0] cur_w = '0;
    int fcnt = 0;
    int conv_idx = 0;
    bit inj_lead = 0, inj_trail = 0, cur_lead = 0, cur_trail = 0;

    function automatic logic [11:0] word_of(input int j);
        case (j % 5)
            0: return 12'hFFF;
            1: return 12'h000;
            2: return 12'hA5A;
            3: return 12'h5A5;
            default: return 12'(j * 37 + 1);
        endcase
    endfunction

    always @(negedge cs_n) begin
        cur_w = word_of(conv_idx);
        conv_idx++;
        cur_lead = inj_lead;
        cur_trail = inj_trail;
        exp_q.push_back({prev_w, inj_lead | inj_trail});
        fcnt = 0;
        sdo = 1'b0;
    end

    always @(negedge sck) begin
        if (!cs_n) begin
            fcnt++;
            if (fcnt == 1) sdo = cur_lead;
            else if (fcnt <= 13) sdo = prev_w[13 - fcnt];
            else sdo = cur_trail;
        end
    end

    always @(posedge cs_n) begin
        if (fcnt >= 14) prev_w = cur_w;
    end

    // ---------------- pin monitor ----------------
    int sck_run, cs_hi_run, since_csf, falls_lo, falls_hi;
    int last_falls, last_acq_falls, last_cs_hi, last_period, width_bad, width_seen;
    logic prev_sck, prev_cs;

    always @(negedge clk) begin
        if (!rst_n) begin
            sck_run = 0; cs_hi_run = 0; since_csf = 0; falls_lo = 0; falls_hi = 0;
            last_falls = 0; last_acq_falls = 0; last_cs_hi = 0; last_period = 0;
            width_bad = 0; width_seen = 0; prev_sck = 1'b1; prev_cs = 1'b1;
        end else begin
            since_csf++;
            if (sck != prev_sck) begin
                if (!sck) begin
                    if (cs_n) falls_hi++;
                    else begin
                        falls_lo++;
                        if (falls_lo > 1) begin
                            width_seen++;
                            if (sck_run != HALF) width_bad++;
                        end
                    end
                end else begin
                    width_seen++;
                    if (sck_run != HALF) width_bad++;
                end
                sck_run = 1;
            end else sck_run++;
            if (cs_n && !prev_cs) begin
                last_falls = falls_lo; falls_lo = 0; cs_hi_run = 1;
            end else if (!cs_n && prev_cs) begin
                last_acq_falls = falls_hi; falls_hi = 0;
                last_cs_hi = cs_hi_run; last_period = since_csf; since_csf = 0;
            end else if (cs_n) cs_hi_run++;
            prev_sck = sck;
            prev_cs = cs_n;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    task automatic pulse_req();
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
    endtask

    task automatic check_frame(input string rq, input bit exp_stale);
        int waited;
        logic [11:0] r;
        exp_t e;
        waited = 0;
        while (!valid && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        chk(valid, rq, "strobe seen", valid, 1);
        if (!valid) return;
        r = result;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
        chk(stale == exp_stale, "R7", "stale marker", stale, exp_stale);
        if (!exp_stale) chk(r == e.w, rq, "result word", r, e.w);
        chk(ferr == e.e, "R8", "framing error", ferr, e.e);
        @(negedge clk);
        chk(!valid && result == r, "R6", "single-cycle strobe, held result", valid, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(cs_n && sck && !busy && !valid && !ferr, "R1", "lines in reset",
            {cs_n, sck, busy, valid, ferr}, 5'b11000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        exp_q.delete();
        chk(cs_n && sck && !busy && !valid && !ferr, "R1", "idle after reset",
            {cs_n, sck, busy, valid, ferr}, 5'b11000);
    endtask

    task automatic t_held();
        pulse_req();
        check_frame("R7", 1'b1);
        repeat (4) @(negedge clk);
        chk(last_falls == 14, "R3", "falls with select low", last_falls, 14);
        chk(last_acq_falls == 0, "R3", "clock held in acquisition", last_acq_falls, 0);
        for (int k = 0; k < 5; k++) begin
            pulse_req();
            check_frame("R5", 1'b0);
        end
    endtask

    task automatic t_busy();
        pulse_req();
        repeat (30) @(negedge clk);
        chk(busy, "R9", "busy mid frame", busy, 1);
        req = 1'b1;
        @(negedge clk); req = 1'b0;
        check_frame("R9", 1'b0);
        repeat (200) @(negedge clk);
        chk(exp_q.size() == 0 && !busy, "R9", "request during frame ignored",
            exp_q.size(), 0);
    endtask

    task automatic t_cont();
        @(negedge clk); free_run = 1'b1;
        for (int k = 0; k < 5; k++) check_frame("R4", 1'b0);
        repeat (20) @(negedge clk);
        chk(last_period == 36 * HALF, "R4", "frame period", last_period, 36 * HALF);
        chk(last_cs_hi == 8 * HALF, "R4", "select high width", last_cs_hi, 8 * HALF);
        chk(last_acq_falls == 4, "R4", "falls during acquisition", last_acq_falls, 4);
        check_frame("R4", 1'b0);
        free_run = 1'b0;
        check_frame("R9", 1'b0);
        repeat (3) @(negedge clk);
        chk(!busy && cs_n && sck, "R9", "idle after continuous stop",
            {busy, cs_n, sck}, 3'b011);
        repeat (200) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "no frame after stop", exp_q.size(), 0);
    endtask

    task automatic t_err();
        inj_lead = 1'b1;
        pulse_req();
        check_frame("R8", 1'b0);
        inj_lead = 1'b0;
        inj_trail = 1'b1;
        pulse_req();
        check_frame("R8", 1'b0);
        inj_trail = 1'b0;
        pulse_req();
        check_frame("R8", 1'b0);
        chk(!ferr, "R8", "error clears on clean frame", ferr, 0);
    endtask

    initial begin
        t_reset();
        t_held();
        t_busy();
        t_cont();
        t_err();
        chk(width_bad == 0 && width_seen > 100, "R2", "clock level widths",
            width_bad, 0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired, run did not complete");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule